// File: doc/BRIEF.md
# Multirate Phased Clock-Enable Controller

This block lets a single base clock pace logic that runs at several slower sample rates. Each slower rate is a whole multiple of the base rate. For every such rate the controller produces one enable strobe per phase. A register fed by one of these strobes updates once per period of its rate, on a chosen phase. The fastest rate in the system is the base clock itself, and its enable is the global clock-enable input with no division.

A global clock-enable input gates every strobe. While it is low, all phased strobes are low and every divider holds its count. A stalled system therefore resumes with the same phase alignment it had when it stopped. The block also drives output-valid strobes: one for the base rate and one for each slower rate, the latter taken from the last phase of that rate. Rates that share a division factor also share one divider, so a factor costs one counter however often it appears. A configuration that holds only a factor of 1 is single-rate: its enable and its valid strobe are the global enable passed straight through.

Each divider is a small state machine with three named next-step states. PH_HOLD: the global enable is low, so the count is kept. PH_STEP: the enable is high and the count is below the factor minus one, so the count goes up by one. PH_WRAP: the enable is high and the count equals the factor minus one, so the count returns to 0. Reset returns every divider to phase 0. It is synchronous by default, and a parameter selects an asynchronous variant instead.

Top module: `mrce_timing_ctrl`

## Requirements
- R1: `base_en` equals `ce_in` in the same cycle.
- R2: For rate r with factor N, `phase_en` holds N bits. They sit in a slice that starts at the sum of the factors of rates 0..r-1, with phase 0 at the lowest bit of the slice. Bit p is high exactly when `ce_in` is high and the number of enabled cycles since reset, taken modulo N, equals p.
- R3: While `ce_in` is low, every bit of `phase_en` is low. No divider advances, so the phase sequence resumes where it stopped on the next enabled cycle.
- R4: A divider at phase N-1 returns to phase 0 on an enabled cycle. Its count never reaches N.
- R5: At most one phase enable of any one rate is high in a cycle.
- R6: `rate_valid[r]` equals the phase N-1 enable of rate r. It is never high while `ce_in` is low.
- R7: `base_valid` equals `ce_in`.
- R8: A rate with factor 1 has one enable, and both that enable and its valid strobe equal `ce_in`.
- R9: Reset returns every divider to phase 0. On the first enabled cycle after reset, the phase-0 enable of every rate is high.
- R10: Rates with the same factor share one divider, and their enable slices are identical every cycle.
- R11: A reset in the middle of a sequence restarts every rate at phase 0, whatever phase it was in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Reset, active high (synchronous by default) |
| ce_in | input | 1 | Global clock enable |
| base_en | output | 1 | Base-rate enable |
| base_valid | output | 1 | Base-rate output-valid strobe |
| phase_en | output | TOTAL_PHASES | Phased enables of all rates, concatenated by rate |
| rate_valid | output | NUM_RATES | Output-valid strobe per slower rate |

## Verification
All outputs are combinational from `ce_in` and the divider registers. A change of `ce_in` therefore appears on every strobe in the same cycle, while a divider step shows one cycle after the enabled edge that causes it. The bench drives inputs just after the falling edge, samples two time units later, well before the next rising edge, and only then counts the enabled edge into its reference total. The expected phase of each rate is that total modulo the factor, and reset sets the total back to zero on the edge where reset is seen.

// File: rtl/mrce_pkg.sv
package mrce_pkg;

    localparam int MAX_RATES = 8;

    typedef int rate_list_t [MAX_RATES];

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_STEP = 2'd1,
        PH_WRAP = 2'd2
    } phase_step_e;

    function automatic int total_phases(rate_list_t f, int n);
        int s;
        s = 0;
        for (int i = 0; i < n; i++) s += f[i];
        return s;
    endfunction

    function automatic int max_factor(rate_list_t f, int n);
        int m;
        m = 1;
        for (int i = 0; i < n; i++) if (f[i] > m) m = f[i];
        return m;
    endfunction

    function automatic int phase_offset(rate_list_t f, int idx);
        int s;
        s = 0;
        for (int i = 0; i < idx; i++) s += f[i];
        return s;
    endfunction

    function automatic int first_with_factor(rate_list_t f, int idx);
        int k;
        k = idx;
        for (int i = idx - 1; i >= 0; i--) if (f[i] == f[idx]) k = i;
        return k;
    endfunction

    function automatic int width_for(int m);
        return (m > 1) ? $clog2(m) : 1;
    endfunction

endpackage

// File: rtl/mrce_phase_counter.sv
module mrce_phase_counter
    import mrce_pkg::*;
#(
    parameter int FACTOR     = 2,
    parameter int CW         = 1,
    parameter bit RESET_SYNC = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_in,
    output logic [CW-1:0] phase
);

    localparam logic [CW-1:0] LAST = CW'(FACTOR - 1);

    phase_step_e   step;
    logic [CW-1:0] phase_nxt;

    always_comb begin
        if (!ce_in)              step = PH_HOLD;
        else if (phase == LAST)  step = PH_WRAP;
        else                     step = PH_STEP;
    end

    always_comb begin
        unique case (step)
            PH_HOLD: phase_nxt = phase;
            PH_STEP: phase_nxt = phase + CW'(1);
            PH_WRAP: phase_nxt = '0;
            default: phase_nxt = '0;
        endcase
    end

    generate
        if (RESET_SYNC) begin : g_sync_rst
            always_ff @(posedge clk) begin
                if (rst) phase <= '0;
                else     phase <= phase_nxt;
            end
        end else begin : g_async_rst
            always_ff @(posedge clk or posedge rst) begin
                if (rst) phase <= '0;
                else     phase <= phase_nxt;
            end
        end
    endgenerate

    assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !ce_in |=> $stable(phase));

    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (ce_in && phase == LAST) |=> phase == '0);

    assert_reset_to_zero_R9: assert property (@(posedge clk)
        rst |=> phase == '0);

endmodule

// File: rtl/mrce_phase_decode.sv
module mrce_phase_decode #(
    parameter int FACTOR = 2,
    parameter int CW     = 1
) (
    input  logic              ce_in,
    input  logic [CW-1:0]     phase,
    output logic [FACTOR-1:0] en,
    output logic              valid
);

    generate
        for (genvar p = 0; p < FACTOR; p++) begin : g_phase
            assign en[p] = ce_in && (phase == CW'(p));
        end
    endgenerate

    assign valid = en[FACTOR-1];

endmodule

// File: rtl/mrce_timing_ctrl.sv
module mrce_timing_ctrl
    import mrce_pkg::*;
#(
    parameter int         NUM_RATES    = 5,
    parameter rate_list_t RATE_FACTORS = '{2, 3, 2, 4, 1, 0, 0, 0},
    parameter bit         RESET_SYNC   = 1'b1,
    localparam int        TOTAL_PHASES = total_phases(RATE_FACTORS, NUM_RATES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce_in,
    output logic                    base_en,
    output logic                    base_valid,
    output logic [TOTAL_PHASES-1:0] phase_en,
    output logic [NUM_RATES-1:0]    rate_valid
);

    localparam int CW = width_for(max_factor(RATE_FACTORS, NUM_RATES));

    logic [NUM_RATES-1:0][CW-1:0] rate_phase;

    assign base_en    = ce_in;
    assign base_valid = ce_in;

    generate
        for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
            localparam int F     = RATE_FACTORS[r];
            localparam int OFF   = phase_offset(RATE_FACTORS, r);
            localparam int OWNER = first_with_factor(RATE_FACTORS, r);

            if (OWNER == r) begin : g_own_counter
                mrce_phase_counter #(
                    .FACTOR     (F),
                    .CW         (CW),
                    .RESET_SYNC (RESET_SYNC)
                ) u_cnt (
                    .clk   (clk),
                    .rst   (rst),
                    .ce_in (ce_in),
                    .phase (rate_phase[r])
                );
            end else begin : g_shared_counter
                assign rate_phase[r] = rate_phase[OWNER];
            end

            mrce_phase_decode #(
                .FACTOR (F),
                .CW     (CW)
            ) u_dec (
                .ce_in (ce_in),
                .phase (rate_phase[r]),
                .en    (phase_en[OFF +: F]),
                .valid (rate_valid[r])
            );

            assert_one_phase_R5: assert property (@(posedge clk) disable iff (rst)
                $onehot0(phase_en[OFF +: F]));

            assert_valid_needs_ce_R6: assert property (@(posedge clk) disable iff (rst)
                rate_valid[r] |-> ce_in);
        end
    endgenerate

    assert_idle_all_low_R3: assert property (@(posedge clk) disable iff (rst)
        !ce_in |-> (phase_en == '0));

endmodule

// File: tb/mrce_timing_ctrl_tb.sv
module mrce_timing_ctrl_tb;
    import mrce_pkg::*;

    localparam int         NR    = 5;
    localparam rate_list_t FACT  = '{2, 3, 2, 4, 1, 0, 0, 0};
    localparam int         TOTAL = total_phases(FACT, NR);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ce_in = 1'b0;
    logic             base_en, base_valid;
    logic [TOTAL-1:0] phase_en;
    logic [NR-1:0]    rate_valid;

    int checks = 0;
    int failures = 0;
    int k = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    mrce_timing_ctrl #(
        .NUM_RATES    (NR),
        .RATE_FACTORS (FACT),
        .RESET_SYNC   (1'b1)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ce_in      (ce_in),
        .base_en    (base_en),
        .base_valid (base_valid),
        .phase_en   (phase_en),
        .rate_valid (rate_valid)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        logic [31:0] exp_s, act_s, exp_v, slice0, slice2;
        chk("R1 base_en", 32'(base_en), 32'(ce_in));
        chk("R7 base_valid", 32'(base_valid), 32'(ce_in));
        for (int r = 0; r < NR; r++) begin
            int off = phase_offset(FACT, r);
            exp_s = '0;
            act_s = '0;
            for (int p = 0; p < FACT[r]; p++) begin
                exp_s[p] = ce_in && ((k % FACT[r]) == p);
                act_s[p] = phase_en[off + p];
            end
            exp_v = 32'(exp_s[FACT[r] - 1]);
            if (FACT[r] == 1) begin
                chk("R8 factor-1 enable", act_s, 32'(ce_in));
                chk("R8 factor-1 valid", 32'(rate_valid[r]), 32'(ce_in));
            end else begin
                chk(!ce_in ? "R3 idle enables" : tag, act_s, exp_s);
                chk("R6 rate_valid", 32'(rate_valid[r]), exp_v);
            end
        end
        slice0 = 32'(phase_en[phase_offset(FACT, 0) +: 2]);
        slice2 = 32'(phase_en[phase_offset(FACT, 2) +: 2]);
        chk("R10 shared factor", slice2, slice0);
    endtask

    task automatic step(logic ce_v, logic rst_v, string tag);
        @(negedge clk);
        ce_in = ce_v;
        rst   = rst_v;
        #2;
        if (!rst_v) check_all(tag);
        @(posedge clk);
        if (rst_v)     k = 0;
        else if (ce_v) k++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step(1'b1, 1'b1, "reset");
        step(1'b0, 1'b0, "R9 idle after reset");
        step(1'b1, 1'b0, "R9 first enabled cycle phase 0");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "R2 R4 continuous");
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], 1'b0, "R2 R4 random enable");
        end
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R3 stall");
        step(1'b1, 1'b0, "R3 resume after stall");
        step(1'b1, 1'b0, "R2 before mid reset");
        step(1'b1, 1'b1, "reset");
        step(1'b1, 1'b0, "R11 restart at phase 0");
        for (int i = 0; i < 100; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1] & lfsr[5] ? 1'b0 : 1'b1, 1'b0, "R2 R4 after reset");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule